// File: doc/BRIEF.md
# Byte-Lane Frame Deinterleaver

This block rebuilds pairs of 16-bit samples for two channels, A and B, from one 8-bit lane that moves two bytes per clock. Double-data-rate capture is modelled upstream, so the block sees two byte inputs each clock. `byte_rise` is the byte taken on the rising half. `byte_fall` is the byte taken on the falling half, which comes later in time. A frame strobe is sampled with each clock and is edge-aligned with the data. When it is high, the rising-half byte of that same clock is byte 0 of a new frame.

One frame holds four bytes and takes two clocks. Once the block has seen a strobe, it keeps assembling frames back to back, even if no further strobe arrives. A strobe that arrives while a frame is half built drops the partial frame, and assembly restarts from that byte. Each byte can have its bit order mirrored before it is assembled. A transmit-enable input gates everything: while it is low, the outputs read zero, the inputs are ignored and alignment is lost.

The control is a three-state machine:
- **HUNT**: no alignment.
- **HEAD**: the next clock carries the A bytes.
- **TAIL**: the next clock carries the B bytes.

Its transitions are:
- **GATE**: any state goes to HUNT while `tx_en` is low.
- **SYNC**: any state goes to TAIL on a strobe, and the A bytes are loaded.
- **CONT**: HEAD goes to TAIL without a strobe, and the A bytes are loaded.
- **DONE**: TAIL goes to HEAD without a strobe, the B bytes are loaded and the words are issued.
- **IDLE**: HUNT stays in HUNT without a strobe.

Top module: `ddr_frame_deint`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `out_valid` is 0 and `chan_a` and `chan_b` are 0x0000.
- R2: In the clock where `frame_in` is high, `byte_rise` is A[15:8] and `byte_fall` is A[7:0]. In the following clock, `byte_rise` is B[15:8] and `byte_fall` is B[7:0]. `chan_a`, `chan_b` and `out_valid`=1 appear after the clock edge that samples the B bytes.
- R3: After reset, and after any cycle with `tx_en` low, `out_valid` stays 0 until a `frame_in` pulse has been sampled with `tx_en` high.
- R4: Once aligned, frames continue every two clocks without further `frame_in` pulses, with one `out_valid` pulse per frame.
- R5: A `frame_in` pulse in the B clock of a partial frame discards that frame. No valid is issued for it, and the pulse's clock becomes the A clock of a new frame.
- R6: With `lane_rev`=1, bit i of every assembled byte is taken from input bit 7-i. With `lane_rev`=0, bits keep their positions.
- R7: While `tx_en` is low, `chan_a` and `chan_b` read 0x0000 and `out_valid` is 0, and `frame_in` and the data inputs have no effect.
- R8: Between `out_valid` pulses, `chan_a` and `chan_b` hold the last issued words.
- R9: Words are passed without value conversion over the full offset-binary range 0x0000 to 0xFFFF.
- R10: `out_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; low zeroes outputs and drops alignment |
| lane_rev | input | 1 | Mirror bit order of each byte when 1 |
| frame_in | input | 1 | Frame strobe, aligned with the rising-half byte |
| byte_rise | input | 8 | Byte captured on the rising half of the clock |
| byte_fall | input | 8 | Byte captured on the falling half of the clock |
| chan_a | output | 16 | Assembled channel A word |
| chan_b | output | 16 | Assembled channel B word |
| out_valid | output | 1 | One-cycle pulse when a new A/B pair is issued |

## Verification
The bench sends traffic with no strobe at all. A design that free-runs before alignment would issue words here. It also places strobes in the B clock of a partial frame. A block that ignores the resync would then issue a word pair torn across two frames.

Both lane orders are driven with asymmetric byte patterns. This exposes a reversal applied to the assembled word instead of to each byte, or a swap of rising and falling bytes. The bench also drops `tx_en` in the middle of a frame and raises it again without a strobe. A design that keeps stale alignment or stale words would show non-zero output or a spurious valid pulse.

// File: rtl/deint_pkg.sv
package deint_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HEAD = 2'd1,
        ST_TAIL = 2'd2
    } deint_state_t;
endpackage

// File: rtl/lane_reorder.sv
module lane_reorder #(
    parameter int LANE_W = 8
) (
    input  logic              rev,
    input  logic [LANE_W-1:0] lane_in,
    output logic [LANE_W-1:0] lane_out
);
    for (genvar i = 0; i < LANE_W; i++) begin : g_bit
        assign lane_out[i] = rev ? lane_in[LANE_W-1-i] : lane_in[i];
    end
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import deint_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_en,
    input  logic         frame_in,
    output deint_state_t state,
    output logic         load_head,
    output logic         load_tail
);
    deint_state_t state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        load_head = 1'b0;
        load_tail = 1'b0;
        if (!tx_en) begin
            state_nxt = ST_HUNT;                // GATE
        end else if (frame_in) begin
            state_nxt = ST_TAIL;                // SYNC
            load_head = 1'b1;
        end else begin
            unique case (state)
                ST_HUNT: state_nxt = ST_HUNT;   // IDLE
                ST_HEAD: begin                  // CONT
                    state_nxt = ST_TAIL;
                    load_head = 1'b1;
                end
                ST_TAIL: begin                  // DONE
                    state_nxt = ST_HEAD;
                    load_tail = 1'b1;
                end
                default: state_nxt = ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/word_assembler.sv
module word_assembler #(
    parameter int LANE_W = 8,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              load_head,
    input  logic              load_tail,
    input  logic [LANE_W-1:0] first_byte,
    input  logic [LANE_W-1:0] second_byte,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b,
    output logic              word_valid
);
    logic [WORD_W-1:0] head_hold;
    logic [WORD_W-1:0] pair_word;

    assign pair_word = {first_byte, second_byte};

    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            head_hold  <= '0;
            word_a     <= '0;
            word_b     <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (load_head) head_hold <= pair_word;
            if (load_tail) begin
                word_a     <= head_hold;
                word_b     <= pair_word;
                word_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddr_frame_deint.sv
module ddr_frame_deint
    import deint_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              lane_rev,
    input  logic              frame_in,
    input  logic [LANE_W-1:0] byte_rise,
    input  logic [LANE_W-1:0] byte_fall,
    output logic [WORD_W-1:0] chan_a,
    output logic [WORD_W-1:0] chan_b,
    output logic              out_valid
);
    logic [LANE_W-1:0] rise_ord;
    logic [LANE_W-1:0] fall_ord;
    logic              load_head;
    logic              load_tail;
    logic [WORD_W-1:0] word_a;
    logic [WORD_W-1:0] word_b;
    logic              word_valid;
    deint_state_t      fsm_state;

    lane_reorder #(.LANE_W(LANE_W)) u_rev_rise (
        .rev(lane_rev), .lane_in(byte_rise), .lane_out(rise_ord)
    );
    lane_reorder #(.LANE_W(LANE_W)) u_rev_fall (
        .rev(lane_rev), .lane_in(byte_fall), .lane_out(fall_ord)
    );

    frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .frame_in(frame_in),
        .state(fsm_state), .load_head(load_head), .load_tail(load_tail)
    );

    word_assembler #(.LANE_W(LANE_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .load_head(load_head), .load_tail(load_tail),
        .first_byte(rise_ord), .second_byte(fall_ord),
        .word_a(word_a), .word_b(word_b), .word_valid(word_valid)
    );

    // Transmit gate acts on the ports at once; the registers clear on the next edge.
    assign chan_a    = tx_en ? word_a : '0;
    assign chan_b    = tx_en ? word_b : '0;
    assign out_valid = tx_en & word_valid;
endmodule

// File: rtl/deint_checker.sv
module deint_checker
    import deint_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              frame_in,
    input logic [WORD_W-1:0] chan_a,
    input logic [WORD_W-1:0] chan_b,
    input logic              out_valid,
    input deint_state_t      fsm_state
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R10
    AST_HUNT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HUNT) |=> !out_valid); // R3
    AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && frame_in) |=> (!out_valid && fsm_state == ST_TAIL)); // R5
    AST_GATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (!out_valid && chan_a == '0 && chan_b == '0)); // R7
    AST_VALID_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(fsm_state) == ST_TAIL && $past(tx_en))); // R2
    AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && tx_en && $past(tx_en)) |-> ($stable(chan_a) && $stable(chan_b))); // R8
endmodule

bind ddr_frame_deint deint_checker #(.WORD_W(WORD_W)) u_deint_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .frame_in(frame_in),
    .chan_a(chan_a), .chan_b(chan_b), .out_valid(out_valid), .fsm_state(fsm_state)
);

// File: tb/tb_ddr_frame_deint.sv
module tb_ddr_frame_deint;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        lane_rev = 1'b0;
    logic        frame_in = 1'b0;
    logic [7:0]  byte_rise = '0;
    logic [7:0]  byte_fall = '0;
    logic [15:0] chan_a;
    logic [15:0] chan_b;
    logic        out_valid;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    int          m_pos = -1;   // -1 unaligned, 0 expect A, 1 expect B
    logic [15:0] m_hold = '0;
    logic [15:0] m_a = '0;
    logic [15:0] m_b = '0;
    logic        m_v = 1'b0;
    int          n_valid = 0;

    always #10 clk = ~clk;  // 50 MHz

    ddr_frame_deint dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .lane_rev(lane_rev),
        .frame_in(frame_in), .byte_rise(byte_rise), .byte_fall(byte_fall),
        .chan_a(chan_a), .chan_b(chan_b), .out_valid(out_valid)
    );

    function automatic logic [7:0] mirror(input logic [7:0] v, input logic r);
        logic [7:0] o;
        for (int k = 0; k < 8; k++) o[k] = r ? v[7-k] : v[k];
        return o;
    endfunction

    task automatic compare();
        logic [15:0] ea = tx_en ? m_a : 16'h0;
        logic [15:0] eb = tx_en ? m_b : 16'h0;
        logic        ev = tx_en & m_v;
        n_vec++;
        if (chan_a !== ea || chan_b !== eb || out_valid !== ev) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h v=%b expected a=%h b=%h v=%b",
                     cur_req, chan_a, chan_b, out_valid, ea, eb, ev);
        end
        if (out_valid === 1'b1) n_valid++;
    endtask

    task automatic step(input logic fr, input logic [7:0] r, input logic [7:0] f);
        logic [15:0] w;
        @(negedge clk);
        frame_in = fr; byte_rise = r; byte_fall = f;
        @(posedge clk);
        w = {mirror(r, lane_rev), mirror(f, lane_rev)};
        if (!rst_n || !tx_en) begin
            m_pos = -1; m_hold = '0; m_a = '0; m_b = '0; m_v = 1'b0;
        end else if (fr) begin
            m_hold = w; m_pos = 1; m_v = 1'b0;
        end else if (m_pos == 0) begin
            m_hold = w; m_pos = 1; m_v = 1'b0;
        end else if (m_pos == 1) begin
            m_a = m_hold; m_b = w; m_v = 1'b1; m_pos = 0;
        end else begin
            m_v = 1'b0;
        end
        #1;
        compare();
    endtask

    task automatic send_frame(input logic strobe, input logic [15:0] a, input logic [15:0] b);
        step(strobe, a[15:8], a[7:0]);
        step(1'b0, b[15:8], b[7:0]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset
        cur_req = "R1";
        tx_en = 1'b1;
        step(1'b1, 8'h12, 8'h34);
        step(1'b0, 8'h56, 8'h78);
        rst_n = 1'b1;
        step(1'b0, 8'h9A, 8'hBC);

        // R3: traffic without a strobe must not issue words
        cur_req = "R3";
        n_valid = 0;
        for (int i = 0; i < 6; i++) step(1'b0, 8'(i * 17), 8'(i * 29 + 3));
        if (n_valid != 0) begin n_bad++; $display("FAIL R3: %0d valids expected 0", n_valid); end
        n_vec++;

        // R2: basic frames, each strobed
        cur_req = "R2";
        send_frame(1'b1, 16'hA1B2, 16'hC3D4);
        step(1'b0, 8'h00, 8'h00);
        send_frame(1'b1, 16'h1357, 16'h2468);

        // R4: free-running frames after one strobe
        cur_req = "R4";
        n_valid = 0;
        send_frame(1'b1, 16'h0F1E, 16'h2D3C);
        for (int i = 0; i < 5; i++) send_frame(1'b0, 16'(16'h1111 * i), 16'(16'hFEDC - i));
        if (n_valid != 6) begin n_bad++; $display("FAIL R4: %0d valids expected 6", n_valid); end
        n_vec++;

        // R5: strobe in the B clock restarts the frame
        cur_req = "R5";
        step(1'b1, 8'hDE, 8'hAD);
        send_frame(1'b1, 16'hBEEF, 16'hCAFE);
        step(1'b1, 8'h11, 8'h22);
        step(1'b1, 8'h33, 8'h44);
        step(1'b0, 8'h55, 8'h66);

        // R8: hold between pulses (no strobe, model holds words; HUNT via gate below)
        cur_req = "R8";
        step(1'b0, 8'h77, 8'h88);

        // R6: lane reversal
        cur_req = "R6";
        lane_rev = 1'b1;
        send_frame(1'b1, 16'h0180, 16'h03C1);
        send_frame(1'b0, 16'h8001, 16'hF00D);
        lane_rev = 1'b0;

        // R9: extremes of the offset-binary range
        cur_req = "R9";
        send_frame(1'b1, 16'h0000, 16'hFFFF);
        send_frame(1'b0, 16'hFFFF, 16'h0000);

        // R7: transmit gate mid frame, then re-enable without a strobe
        cur_req = "R7";
        step(1'b0, 8'hAB, 8'hCD);
        tx_en = 1'b0;
        step(1'b0, 8'hEF, 8'h01);
        step(1'b1, 8'h23, 8'h45);
        step(1'b0, 8'h67, 8'h89);
        tx_en = 1'b1;
        n_valid = 0;
        for (int i = 0; i < 4; i++) step(1'b0, 8'hF0, 8'h0F);
        if (n_valid != 0) begin n_bad++; $display("FAIL R7: %0d valids expected 0", n_valid); end
        n_vec++;
        send_frame(1'b1, 16'h5AA5, 16'hA55A);

        // R10 and mixed random traffic
        cur_req = "R10";
        for (int i = 0; i < 400; i++) begin
            lane_rev = ($urandom % 4) == 0;
            tx_en    = ($urandom % 16) != 0;
            step(($urandom % 5) == 0, 8'($urandom), 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule